// File: doc/BRIEF.md
# Software Interrupt Priority Arbiter

The arbiter receives software interrupt requests from an instruction decoder and decides when each one is handed to the core. There are five kinds of request: one that cannot be masked and four that can. The four maskable kinds are three numbered levels (0, 1 and 2) and one "lowest" kind that ranks below level 0. Every request is weighed against the core's current priority level, which arrives on `ccpl_i`. A request that cannot be taken yet is held in a pending bit until the level falls far enough.

Once a request is accepted, a sequencer runs. For a maskable request it first waits a fixed number of cycles, which lets a few following instructions complete. For the non-maskable request it skips that wait. The sequencer then strobes NOP injection for a fixed number of cycles. It ends with a one-cycle vector pulse that carries the vector index and the priority level the core must adopt. Servicing the lowest kind leaves the level where it was, so a level-0 request can still preempt its handler.

Top module: `swi_prio_arb`

## Requirements
- R1: `req_kind_i` is decoded as 0 = lowest, 1 = level 0, 2 = level 1, 3 = level 2, 4 = non-maskable. Codes 5 to 7 are ignored. `vector_idx_o` equals the accepted kind's code.
- R2: A non-maskable request is accepted whenever the sequencer is idle, whatever the value of `ccpl_i`. `inject_nop_o` is high in the 3 cycles after the accepting edge, with no wait before them, and the vector pulse follows in the next cycle.
- R3: A level-n request (n = 0..2) is accepted when n >= `ccpl_i`, including the case where n equals `ccpl_i`.
- R4: After a maskable request is accepted, 3 wait cycles pass, then 3 NOP cycles. The vector pulse appears in the 7th cycle after the accepting edge.
- R5: A level request below `ccpl_i` produces no output. It stays pending and is served once `ccpl_i` is lowered to a value at or below its level.
- R6: The lowest kind is accepted only when `ccpl_i` is 0, and otherwise stays pending. Its `new_ccpl_o` equals `ccpl_i` at acceptance.
- R7: `new_ccpl_o` is n+1 for a level-n request and 3 for the non-maskable request.
- R8: When several requests are eligible, the order is non-maskable, then level 2, level 1, level 0, and lowest last.
- R9: A second request of a kind that is already pending merges into the same bit and gives a single service.
- R10: A request that arrives while the sequencer is busy is held. It can be accepted on the second edge after the vector pulse of the request in service.
- R11: Reset (`rst_ni` low) forces all outputs low and clears every pending bit.
- R12: `vector_valid_o` lasts one cycle. It comes right after exactly 3 consecutive `inject_nop_o` cycles, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Software request strobe from the decoder |
| req_kind_i | input | 3 | Request kind code |
| ccpl_i | input | 2 | Current core priority level |
| inject_nop_o | output | 1 | Force a NOP into the pipeline this cycle |
| vector_valid_o | output | 1 | Vector index and new level are valid |
| vector_idx_o | output | 3 | Vector index of the serviced request |
| new_ccpl_o | output | 2 | Priority level the core adopts |

## Verification
Each accepted request has a due cycle. For the non-maskable kind it is the accepting edge plus 3. For every maskable kind it is the accepting edge plus 6. When a request waits on a pending bit or on a busy sequencer, its accepting edge is the edge after `ccpl_i` drops, or 8 cycles after the previous maskable acceptance. The driver pushes each expected item with its due cycle, index and level. The monitor samples on the falling clock edge and compares each vector pulse against the queue head, including the cycle number and the length of the NOP run before it. Requests that must stay silent are checked by counting vector pulses over a window longer than any service.

// File: rtl/swi_pkg.sv
package swi_pkg;
  localparam int NKIND = 5;

  typedef enum logic [2:0] {
    K_LOW = 3'd0,
    K_L0  = 3'd1,
    K_L1  = 3'd2,
    K_L2  = 3'd3,
    K_NMI = 3'd4
  } swi_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_NOP,
    S_VEC
  } seq_state_e;
endpackage

// File: rtl/swi_pending.sv
module swi_pending #(
  parameter int N = swi_pkg::NKIND
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/swi_select.sv
module swi_select
  import swi_pkg::*;
#(
  parameter int N = NKIND
) (
  input  logic [N-1:0] cand_i,
  input  logic [1:0]   ccpl_i,
  input  logic         en_i,
  output logic [N-1:0] grant_o,
  output logic [2:0]   kind_o,
  output logic         hit_o
);
  logic [N-1:0] elig;

  for (genvar k = 0; k < N; k++) begin : g_elig
    if (k == int'(K_LOW)) begin : g_low
      assign elig[k] = (ccpl_i == 2'd0);
    end else if (k == int'(K_NMI)) begin : g_nmi
      assign elig[k] = 1'b1;
    end else begin : g_lvl
      assign elig[k] = (ccpl_i <= 2'(k - 1));
    end
  end

  always_comb begin
    grant_o = '0;
    kind_o  = '0;
    hit_o   = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (en_i && !hit_o && cand_i[k] && elig[k]) begin
        grant_o[k] = 1'b1;
        kind_o     = 3'(k);
        hit_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/swi_seq.sv
module swi_seq
  import swi_pkg::*;
#(
  parameter int DELAY_CYC = 3,
  parameter int NOP_CYC   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] kind_i,
  input  logic [1:0] ccpl_i,
  output logic       idle_o,
  output logic       inject_nop_o,
  output logic       vector_valid_o,
  output logic [2:0] vector_idx_o,
  output logic [1:0] new_ccpl_o
);
  localparam int CMAX = (DELAY_CYC > NOP_CYC) ? DELAY_CYC : NOP_CYC;
  localparam int CW   = (CMAX > 1) ? $clog2(CMAX + 1) : 1;
  localparam logic [CW-1:0] DLY_LD = CW'((DELAY_CYC > 0) ? DELAY_CYC - 1 : 0);
  localparam logic [CW-1:0] NOP_LD = CW'(NOP_CYC - 1);

  seq_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    kind_q;
  logic [1:0]    lvl_q, lvl_d;

  always_comb begin
    unique case (kind_i)
      K_NMI:   lvl_d = 2'd3;
      K_LOW:   lvl_d = ccpl_i;       // lowest kind keeps the level
      default: lvl_d = kind_i[1:0];  // level n -> n+1 == kind code
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      kind_q <= '0;
      lvl_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          kind_q <= kind_i;
          lvl_q  <= lvl_d;
          if (kind_i == K_NMI || DELAY_CYC == 0) begin
            st_q  <= S_NOP;
            cnt_q <= NOP_LD;
          end else begin
            st_q  <= S_WAIT;
            cnt_q <= DLY_LD;
          end
        end
        S_WAIT: if (cnt_q == '0) begin
          st_q  <= S_NOP;
          cnt_q <= NOP_LD;
        end else cnt_q <= cnt_q - 1'b1;
        S_NOP: if (cnt_q == '0) st_q <= S_VEC;
               else cnt_q <= cnt_q - 1'b1;
        S_VEC: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign idle_o         = (st_q == S_IDLE);
  assign inject_nop_o   = (st_q == S_NOP);
  assign vector_valid_o = (st_q == S_VEC);
  assign vector_idx_o   = vector_valid_o ? kind_q : '0;
  assign new_ccpl_o     = vector_valid_o ? lvl_q : '0;
endmodule

// File: rtl/swi_prio_arb.sv
module swi_prio_arb
  import swi_pkg::*;
#(
  parameter int DELAY_CYC = 3,
  parameter int NOP_CYC   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [2:0] req_kind_i,
  input  logic [1:0] ccpl_i,
  output logic       inject_nop_o,
  output logic       vector_valid_o,
  output logic [2:0] vector_idx_o,
  output logic [1:0] new_ccpl_o
);
  logic [NKIND-1:0] req_vec, pend, cand, grant;
  logic [2:0]       sel_kind;
  logic             sel_hit, seq_idle;

  always_comb begin
    req_vec = '0;
    if (req_valid_i && int'(req_kind_i) < NKIND) req_vec[req_kind_i] = 1'b1;
  end

  assign cand = pend | req_vec;

  swi_pending #(.N(NKIND)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_vec),
    .clr_i  (grant),
    .pend_o (pend)
  );

  swi_select #(.N(NKIND)) u_sel (
    .cand_i  (cand),
    .ccpl_i  (ccpl_i),
    .en_i    (seq_idle),
    .grant_o (grant),
    .kind_o  (sel_kind),
    .hit_o   (sel_hit)
  );

  swi_seq #(.DELAY_CYC(DELAY_CYC), .NOP_CYC(NOP_CYC)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (sel_hit),
    .kind_i         (sel_kind),
    .ccpl_i         (ccpl_i),
    .idle_o         (seq_idle),
    .inject_nop_o   (inject_nop_o),
    .vector_valid_o (vector_valid_o),
    .vector_idx_o   (vector_idx_o),
    .new_ccpl_o     (new_ccpl_o)
  );
endmodule

// File: rtl/swi_prio_arb_chk.sv
module swi_prio_arb_chk #(
  parameter int NOP_CYC = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       inject_nop_o,
  input logic       vector_valid_o,
  input logic [2:0] vector_idx_o,
  input logic [1:0] new_ccpl_o
);
  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= 0;
    else if (inject_nop_o) run_q <= run_q + 1;
    else                   run_q <= 0;
  end

  // R12
  nop_vec_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inject_nop_o && vector_valid_o));

  // R12
  vec_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_valid_o |=> !vector_valid_o);

  // R12
  nop_run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_valid_o |-> run_q == NOP_CYC);

  // R12
  nop_then_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(inject_nop_o) |-> vector_valid_o);

  // R7
  nmi_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vector_valid_o && vector_idx_o == 3'd4) |-> new_ccpl_o == 2'd3);

  // R7
  lvl_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vector_valid_o && vector_idx_o inside {3'd1, 3'd2, 3'd3}) |-> new_ccpl_o == vector_idx_o[1:0]);

  // R1
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_valid_o |-> vector_idx_o <= 3'd4);
endmodule

bind swi_prio_arb swi_prio_arb_chk #(.NOP_CYC(NOP_CYC)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .inject_nop_o   (inject_nop_o),
  .vector_valid_o (vector_valid_o),
  .vector_idx_o   (vector_idx_o),
  .new_ccpl_o     (new_ccpl_o)
);

// File: tb/tb_swi_prio_arb.sv
module tb_swi_prio_arb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [2:0] req_kind_i = '0;
  logic [1:0] ccpl_i = '0;
  logic       inject_nop_o, vector_valid_o;
  logic [2:0] vector_idx_o;
  logic [1:0] new_ccpl_o;

  localparam int KLOW = 0, KL0 = 1, KL1 = 2, KL2 = 3, KNMI = 4;

  always #10 clk = ~clk;  // 50 MHz

  swi_prio_arb dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
    .ccpl_i(ccpl_i), .inject_nop_o(inject_nop_o), .vector_valid_o(vector_valid_o),
    .vector_idx_o(vector_idx_o), .new_ccpl_o(new_ccpl_o)
  );

  typedef struct {
    int    due;
    int    idx;
    int    lvl;
    string r;
  } item_t;

  item_t exp_q[$];
  int cyc = 0, total = 0, bad = 0, vec_seen = 0, b_run = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string r, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, expv);
    end
  endtask

  // driver side: expected item for a request accepted at edge acc
  task automatic expect_vec(int acc, int kind, int lvl, string r);
    item_t it;
    it.due = acc + ((kind == KNMI) ? 3 : 6);
    it.idx = kind;
    it.lvl = lvl;
    it.r   = r;
    exp_q.push_back(it);
  endtask

  task automatic pulse(int kind);
    req_valid_i = 1'b1;
    req_kind_i  = 3'(kind);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst_ni) b_run = 0;
    else begin
      if (inject_nop_o) b_run++;
      if (vector_valid_o) begin
        vec_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected vector", int'(vector_idx_o), -1);
        else begin
          item_t it;
          it = exp_q.pop_front();
          chk(cyc == it.due, {it.r, " due cycle"}, cyc, it.due);
          chk(int'(vector_idx_o) == it.idx, {it.r, " vector idx"}, int'(vector_idx_o), it.idx);
          chk(int'(new_ccpl_o) == it.lvl, {it.r, " new level"}, int'(new_ccpl_o), it.lvl);
          chk(b_run == 3, "R12 nop run before vector", b_run, 3);
        end
        b_run = 0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int v0;
    wait_cyc(3);
    // R11 reset state
    chk(inject_nop_o == 1'b0 && vector_valid_o == 1'b0, "R11 outputs in reset",
        int'({inject_nop_o, vector_valid_o}), 0);
    rst_ni = 1'b1;
    wait_cyc(2);

    // R3 R4 R7: level 1 at equal level
    ccpl_i = 2'd1;
    expect_vec(cyc + 1, KL1, 2, "R3 level1 at ccpl1");
    pulse(KL1);
    wait_cyc(10);

    // R2: non-maskable at level 3
    ccpl_i = 2'd3;
    expect_vec(cyc + 1, KNMI, 3, "R2 nmi at ccpl3");
    pulse(KNMI);
    wait_cyc(8);

    // R6: lowest at level 0 keeps level
    ccpl_i = 2'd0;
    expect_vec(cyc + 1, KLOW, 0, "R6 lowest at ccpl0");
    pulse(KLOW);
    wait_cyc(10);

    // R4 R7: level 2
    ccpl_i = 2'd2;
    expect_vec(cyc + 1, KL2, 3, "R4 level2 at ccpl2");
    pulse(KL2);
    wait_cyc(10);

    // R5: level 0 below ccpl pends
    v0 = vec_seen;
    pulse(KL0);
    wait_cyc(12);
    chk(vec_seen == v0, "R5 pending stays silent", vec_seen - v0, 0);
    ccpl_i = 2'd0;
    expect_vec(cyc + 1, KL0, 1, "R5 pending level0 served");
    wait_cyc(10);

    // R6: lowest pends above 0
    ccpl_i = 2'd1;
    v0 = vec_seen;
    pulse(KLOW);
    wait_cyc(10);
    chk(vec_seen == v0, "R6 lowest held at ccpl1", vec_seen - v0, 0);
    ccpl_i = 2'd0;
    expect_vec(cyc + 1, KLOW, 0, "R6 pending lowest served");
    wait_cyc(10);

    // R8: priority order of pending set
    ccpl_i = 2'd3;
    pulse(KLOW);
    pulse(KL0);
    pulse(KL1);
    pulse(KL2);
    wait_cyc(3);
    ccpl_i = 2'd0;
    expect_vec(cyc + 1,  KL2,  3, "R8 first level2");
    expect_vec(cyc + 9,  KL1,  2, "R8 second level1");
    expect_vec(cyc + 17, KL0,  1, "R8 third level0");
    expect_vec(cyc + 25, KLOW, 0, "R8 last lowest");
    wait_cyc(36);

    // R9: repeat request merges
    ccpl_i = 2'd3;
    v0 = vec_seen;
    pulse(KL1);
    pulse(KL1);
    wait_cyc(5);
    ccpl_i = 2'd1;
    expect_vec(cyc + 1, KL1, 2, "R9 merged level1");
    wait_cyc(25);
    chk(vec_seen - v0 == 1, "R9 single service", vec_seen - v0, 1);

    // R10: request while busy
    ccpl_i = 2'd0;
    expect_vec(cyc + 1, KL2, 3, "R10 first in service");
    expect_vec(cyc + 9, KL0, 1, "R10 held while busy");
    pulse(KL2);
    pulse(KL0);
    wait_cyc(20);

    // R2 R8: non-maskable ahead of a pending level
    ccpl_i = 2'd3;
    pulse(KL0);
    expect_vec(cyc + 1, KNMI, 3, "R2 nmi over pending");
    pulse(KNMI);
    wait_cyc(8);
    ccpl_i = 2'd0;
    expect_vec(cyc + 1, KL0, 1, "R5 level0 after nmi");
    wait_cyc(10);

    // R11: reset clears pending
    ccpl_i = 2'd3;
    v0 = vec_seen;
    pulse(KL1);
    rst_ni = 1'b0;
    wait_cyc(2);
    rst_ni = 1'b1;
    ccpl_i = 2'd0;
    wait_cyc(15);
    chk(vec_seen == v0, "R11 pending cleared by reset", vec_seen - v0, 0);

    // R1: undefined kind code ignored
    v0 = vec_seen;
    pulse(5);
    pulse(7);
    wait_cyc(12);
    chk(vec_seen == v0, "R1 undefined kind ignored", vec_seen - v0, 0);

    chk(exp_q.size() == 0, "R12 all expected vectors seen", exp_q.size(), 0);
    finish_run();
  end
endmodule